// File: doc/BRIEF.md
# Lockstep Four-Slot Wide-Word Execute Core

This core executes one 128-bit instruction word per clock. Each word holds four 32-bit operation slots that issue together and advance in strict lockstep. Every slot reads the register file before any slot writes it, so the operations in one word act on a single snapshot of the machine state. The core has no dependency checks and no interlocks. Each operation class has a fixed result latency. A consumer that reads a destination too early gets the old value, and schedule correctness is left to the code generator.

The fetch side provides a word together with a valid flag, and the core drives the address of the word it wants next. A stall input freezes the whole core. No slot, pending result or program counter can move on its own while it is set. Two writes that land on one register in the same cycle are resolved by a fixed priority and recorded in a sticky flag. A combinational debug port reads any register.

Top module: `vliw_core`

## Requirements
- R1: Slot k of `instr_i` occupies bits [32k+31:32k]. In each slot, the opcode is in [31:28], the destination in [27:23], source A in [22:18], source B in [17:13], and a signed 13-bit immediate in [12:0]. A register is selected by the low four bits of its field. Opcodes: 0 no-op, 1 add (A+B), 2 move (A), 3 add-immediate (A+imm), 4 slow add (A+B), 5 jump. Any other code acts as a no-op.
- R2: Every operand in a word reads the register values from before that word. A word that moves r2 into r1 and r1 into r2 exchanges the two registers.
- R3: When the destinations are distinct, permuting the slots of a word does not change the result.
- R4: The add, move and add-immediate results are visible to the next word that issues.
- R5: A slow add result stays invisible to the next non-stalled cycle and becomes visible one cycle after that. A read that comes earlier returns the stale value, without any stall. Cycles with valid low still count toward the latency.
- R6: On an issued word, `pc_o` becomes the target (immediate bits [11:0]) of the lowest-numbered jump slot. Other jumps in the word are no-ops, and the word's other operations still complete. With no jump, `pc_o` increments. When valid is low, `pc_o` holds.
- R7: While `stall_i` is high, the program counter, the registers and the pending slow results all hold. No delayed write is dropped or reordered.
- R8: When several writes retire to one register in the same cycle, the higher slot wins. Within one slot, a current-word write beats a delayed write. `wr_conflict_o` is then set, and it stays set until reset.
- R9: Register 0 always reads zero. Writes to it are discarded and never count as a conflict.
- R10: After reset, `pc_o` is 0, all registers are 0, `wr_conflict_o` is 0 and no delayed write is pending.
- R11: `dbg_data_o` shows the current value of register `dbg_idx_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_i | input | 128 | Four operation slots |
| instr_valid_i | input | 1 | Word on `instr_i` is present |
| stall_i | input | 1 | Freeze the whole core |
| pc_o | output | 12 | Address of the next word to fetch |
| dbg_idx_i | input | 4 | Debug register select |
| dbg_data_o | output | 32 | Debug register value |
| wr_conflict_o | output | 1 | Sticky same-cycle write collision flag |

## Verification
A delayed slow-add result can retire in the same cycle as a current-word write to the same register. The bench provokes this by following a slow add with a word whose fast operation targets the same destination from a lower or an equal slot. It then reads the winner through the debug port and checks that the conflict flag has risen. The bench also places stalls between a slow add and its retirement, to show that the delayed write survives the freeze intact. Random traffic with mixed stalls and bubbles is compared against a slot-by-slot reference model on every cycle.

// File: rtl/vliw_pkg.sv
`timescale 1ns/1ps
package vliw_pkg;
    localparam int DW      = 32;
    localparam int SLOT_W  = 32;
    localparam int FIELD_W = 5;
    localparam int IMM_W   = 13;

    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_ADD  = 4'd1,
        OP_MOV  = 4'd2,
        OP_ADDI = 4'd3,
        OP_SLOW = 4'd4,
        OP_JUMP = 4'd5
    } opc_e;

    typedef struct packed {
        logic               en;
        logic [FIELD_W-1:0] idx;
        logic [DW-1:0]      data;
    } wreq_t;
endpackage

// File: rtl/vliw_slot_exec.sv
`timescale 1ns/1ps
module vliw_slot_exec
    import vliw_pkg::*;
#(
    parameter int PC_W = 12
) (
    input  logic [SLOT_W-1:0]  op_word,
    input  logic               issue,
    input  logic [DW-1:0]      a_val,
    input  logic [DW-1:0]      b_val,
    output logic [FIELD_W-1:0] a_idx,
    output logic [FIELD_W-1:0] b_idx,
    output wreq_t              fast_w,
    output wreq_t              slow_w,
    output logic               is_jump,
    output logic [PC_W-1:0]    target
);
    opc_e          opc;
    logic [DW-1:0] imm_ext;

    assign opc     = opc_e'(op_word[31:28]);
    assign a_idx   = op_word[22:18];
    assign b_idx   = op_word[17:13];
    assign imm_ext = {{(DW-IMM_W){op_word[IMM_W-1]}}, op_word[IMM_W-1:0]};
    assign target  = op_word[PC_W-1:0];

    always_comb begin
        fast_w      = '0;
        slow_w      = '0;
        is_jump     = 1'b0;
        fast_w.idx  = op_word[27:23];
        slow_w.idx  = op_word[27:23];
        slow_w.data = a_val + b_val;
        unique case (opc)
            OP_ADD:  begin fast_w.en = issue; fast_w.data = a_val + b_val;   end
            OP_MOV:  begin fast_w.en = issue; fast_w.data = a_val;           end
            OP_ADDI: begin fast_w.en = issue; fast_w.data = a_val + imm_ext; end
            OP_SLOW: slow_w.en = issue;
            OP_JUMP: is_jump   = issue;
            default: ;
        endcase
    end
endmodule

// File: rtl/vliw_delay_line.sv
`timescale 1ns/1ps
module vliw_delay_line
    import vliw_pkg::*;
#(
    parameter int N   = 4,
    parameter int LAT = 2,
    localparam int DEPTH = (LAT > 1) ? LAT - 1 : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           advance,
    input  wreq_t [N-1:0]  in_w,
    output wreq_t [N-1:0]  out_w
);
    generate
        if (LAT > 1) begin : g_pipe
            wreq_t [DEPTH-1:0][N-1:0] stage_d, stage_q;

            always_comb begin
                stage_d = stage_q;
                if (advance) begin
                    stage_d[0] = in_w;
                    for (int i = 1; i < DEPTH; i++) stage_d[i] = stage_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= stage_d;
            end

            assign out_w = stage_q[DEPTH-1];

            // pending writes frozen while the core is held
            assert_hold_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !advance |=> $stable(stage_q));
        end else begin : g_wire
            assign out_w = in_w;
        end
    endgenerate
endmodule

// File: rtl/vliw_regfile.sv
`timescale 1ns/1ps
module vliw_regfile
    import vliw_pkg::*;
#(
    parameter int NREG = 16,
    parameter int NRD  = 8,
    parameter int NWP  = 8,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NRD-1:0][AW-1:0]    rd_idx,
    output logic [NRD-1:0][DW-1:0]    rd_data,
    input  wreq_t [NWP-1:0]           wr,
    input  logic [AW-1:0]             dbg_idx,
    output logic [DW-1:0]             dbg_data,
    output logic                      clash
);
    logic [NREG-1:0][DW-1:0] regs_d, regs_q;
    logic [NWP-1:0]          live;

    always_comb begin
        for (int w = 0; w < NWP; w++)
            live[w] = wr[w].en && (wr[w].idx[AW-1:0] != '0);
    end

    // later port index has priority
    always_comb begin
        regs_d = regs_q;
        for (int w = 0; w < NWP; w++)
            if (live[w]) regs_d[wr[w].idx[AW-1:0]] = wr[w].data;
        regs_d[0] = '0;
    end

    always_comb begin
        clash = 1'b0;
        for (int i = 0; i < NWP; i++)
            for (int j = i + 1; j < NWP; j++)
                if (live[i] && live[j] && (wr[i].idx[AW-1:0] == wr[j].idx[AW-1:0]))
                    clash = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        for (int r = 0; r < NRD; r++) rd_data[r] = regs_q[rd_idx[r]];
    end
    assign dbg_data = regs_q[dbg_idx];

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (live == '0) |=> $stable(regs_q));

    assert_zero_reg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_idx == '0) |-> (dbg_data == '0));
endmodule

// File: rtl/vliw_core.sv
`timescale 1ns/1ps
module vliw_core
    import vliw_pkg::*;
#(
    parameter int SLOTS    = 4,
    parameter int NREG     = 16,
    parameter int PC_W     = 12,
    parameter int SLOW_LAT = 2,
    localparam int AW      = $clog2(NREG),
    localparam int WORD_W  = SLOTS * SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] instr_i,
    input  logic              instr_valid_i,
    input  logic              stall_i,
    output logic [PC_W-1:0]   pc_o,
    input  logic [AW-1:0]     dbg_idx_i,
    output logic [DW-1:0]     dbg_data_o,
    output logic              wr_conflict_o
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            conflict;
    } core_st_t;

    core_st_t st_d, st_q;

    logic                         advance, issue;
    logic [2*SLOTS-1:0][AW-1:0]   rd_idx;
    logic [2*SLOTS-1:0][DW-1:0]   rd_data;
    wreq_t [SLOTS-1:0]            fast_w, slow_w, late_w;
    wreq_t [2*SLOTS-1:0]          wr_port;
    logic  [SLOTS-1:0]            jmp_req, jmp_take;
    logic  [SLOTS-1:0][PC_W-1:0]  jmp_tgt;
    logic  [PC_W-1:0]             jmp_pc;
    logic                         clash;

    assign advance = !stall_i;
    assign issue   = instr_valid_i && !stall_i;

    generate
        for (genvar s = 0; s < SLOTS; s++) begin : g_slot
            logic [FIELD_W-1:0] a_f, b_f;
            vliw_slot_exec #(.PC_W(PC_W)) u_exec (
                .op_word (instr_i[s*SLOT_W +: SLOT_W]),
                .issue   (issue),
                .a_val   (rd_data[2*s]),
                .b_val   (rd_data[2*s+1]),
                .a_idx   (a_f),
                .b_idx   (b_f),
                .fast_w  (fast_w[s]),
                .slow_w  (slow_w[s]),
                .is_jump (jmp_req[s]),
                .target  (jmp_tgt[s])
            );
            assign rd_idx[2*s]   = a_f[AW-1:0];
            assign rd_idx[2*s+1] = b_f[AW-1:0];

            // per slot: delayed result first, then current-word result
            always_comb begin
                wr_port[2*s]     = late_w[s];
                wr_port[2*s].en  = late_w[s].en && advance;
                wr_port[2*s+1]   = fast_w[s];
            end
        end
    endgenerate

    vliw_delay_line #(.N(SLOTS), .LAT(SLOW_LAT)) u_delay (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .in_w    (slow_w),
        .out_w   (late_w)
    );

    vliw_regfile #(.NREG(NREG), .NRD(2*SLOTS), .NWP(2*SLOTS)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .wr       (wr_port),
        .dbg_idx  (dbg_idx_i),
        .dbg_data (dbg_data_o),
        .clash    (clash)
    );

    // lowest-numbered jump slot wins
    always_comb begin
        jmp_take = '0;
        jmp_pc   = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (jmp_req[s]) begin
                jmp_take    = '0;
                jmp_take[s] = 1'b1;
                jmp_pc      = jmp_tgt[s];
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (issue) st_d.pc = (jmp_take != '0) ? jmp_pc : st_q.pc + 1'b1;
        if (clash) st_d.conflict = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_o          = st_q.pc;
    assign wr_conflict_o = st_q.conflict;

    assert_stall_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> $stable(pc_o));

    assert_seq_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !(|jmp_req)) |=> (pc_o == $past(pc_o) + 1'b1));

    assert_bubble_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid_i && !stall_i) |=> $stable(pc_o));

    assert_one_jump_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(jmp_take));

    assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_conflict_o |=> wr_conflict_o);
endmodule

// File: tb/vliw_core_tb.sv
`timescale 1ns/1ps
module vliw_core_tb;
    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [127:0]  instr_i = '0;
    logic          instr_valid_i = 1'b0;
    logic          stall_i = 1'b0;
    logic [11:0]   pc_o;
    logic [3:0]    dbg_idx_i = '0;
    logic [31:0]   dbg_data_o;
    logic          wr_conflict_o;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] m_regs [16];
    logic        m_pen  [4];
    logic [3:0]  m_pidx [4];
    logic [31:0] m_pdat [4];
    logic [11:0] m_pc;
    logic        m_conf;

    always #4 clk = ~clk;

    vliw_core u_dut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .instr_valid_i(instr_valid_i),
        .stall_i(stall_i), .pc_o(pc_o), .dbg_idx_i(dbg_idx_i), .dbg_data_o(dbg_data_o),
        .wr_conflict_o(wr_conflict_o)
    );

    function automatic logic [31:0] op(int opc, int d, int a, int b, int imm);
        logic [31:0] w;
        w = '0;
        w[31:28] = opc[3:0];
        w[27:23] = d[4:0];
        w[22:18] = a[4:0];
        w[17:13] = b[4:0];
        w[12:0]  = imm[12:0];
        return w;
    endfunction

    function automatic logic [127:0] word4(logic [31:0] s0, logic [31:0] s1,
                                           logic [31:0] s2, logic [31:0] s3);
        return {s3, s2, s1, s0};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int r = 0; r < 16; r++) m_regs[r] = '0;
        for (int s = 0; s < 4; s++) begin m_pen[s] = 0; m_pidx[s] = 0; m_pdat[s] = 0; end
        m_pc = '0;
        m_conf = 0;
    endtask

    task automatic model_step(logic [127:0] w, logic v, logic st);
        logic [31:0] snap [16];
        logic        ce [8];
        logic [3:0]  ci [8];
        logic [31:0] cd [8];
        logic        hit [16];
        logic        npen [4];
        logic [3:0]  npidx [4];
        logic [31:0] npdat [4];
        logic [11:0] npc;
        logic        jumped;
        if (st) return;
        for (int r = 0; r < 16; r++) begin snap[r] = m_regs[r]; hit[r] = 0; end
        npc = v ? m_pc + 12'd1 : m_pc;
        jumped = 0;
        for (int s = 0; s < 4; s++) begin
            logic [31:0] sw, av, bv, iv;
            ce[2*s] = m_pen[s]; ci[2*s] = m_pidx[s]; cd[2*s] = m_pdat[s];
            ce[2*s+1] = 0; ci[2*s+1] = 0; cd[2*s+1] = 0;
            npen[s] = 0; npidx[s] = 0; npdat[s] = 0;
            sw = w[32*s +: 32];
            av = snap[sw[21:18]];
            bv = snap[sw[16:13]];
            iv = {{19{sw[12]}}, sw[12:0]};
            if (v) begin
                case (sw[31:28])
                    4'd1: begin ce[2*s+1] = 1; ci[2*s+1] = sw[26:23]; cd[2*s+1] = av + bv; end
                    4'd2: begin ce[2*s+1] = 1; ci[2*s+1] = sw[26:23]; cd[2*s+1] = av; end
                    4'd3: begin ce[2*s+1] = 1; ci[2*s+1] = sw[26:23]; cd[2*s+1] = av + iv; end
                    4'd4: begin npen[s] = 1; npidx[s] = sw[26:23]; npdat[s] = av + bv; end
                    4'd5: if (!jumped) begin jumped = 1; npc = sw[11:0]; end
                    default: ;
                endcase
            end
        end
        for (int k = 0; k < 8; k++) begin
            if (ce[k] && ci[k] != 0) begin
                if (hit[ci[k]]) m_conf = 1;
                hit[ci[k]] = 1;
                m_regs[ci[k]] = cd[k];
            end
        end
        for (int s = 0; s < 4; s++) begin m_pen[s] = npen[s]; m_pidx[s] = npidx[s]; m_pdat[s] = npdat[s]; end
        m_pc = npc;
    endtask

    task automatic compare_all(string tag);
        chk({tag, " pc"}, {20'd0, pc_o}, {20'd0, m_pc});
        chk({tag, " conflict"}, {31'd0, wr_conflict_o}, {31'd0, m_conf});
        for (int r = 0; r < 16; r++) begin
            dbg_idx_i = r[3:0];
            #0.1;
            chk($sformatf("%s R11 reg%0d", tag, r), dbg_data_o, m_regs[r]);
        end
    endtask

    task automatic step(logic [127:0] w, logic v, logic st, string tag);
        instr_i = w; instr_valid_i = v; stall_i = st;
        model_step(w, v, st);
        @(posedge clk);
        #1;
        compare_all(tag);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired (R7 hang) actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        compare_all("R10 reset");
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R4: add-immediate loads visible to the next word
        step(word4(op(3,1,0,0,5), op(3,2,0,0,7), op(3,3,0,0,-3), op(3,4,0,0,100)), 1, 0, "R1 R4 addi");
        chk("R4 r3 negative imm", m_regs[3], 32'hFFFF_FFFD);
        // R2: swap
        step(word4(op(2,1,2,0,0), op(2,2,1,0,0), 0, 0), 1, 0, "R2 swap");
        chk("R2 r1 after swap", m_regs[1], 32'd7);
        // R3: same swap with slots permuted swaps back
        step(word4(0, op(2,2,1,0,0), 0, op(2,1,2,0,0)), 1, 0, "R3 permuted swap");
        chk("R3 r1 restored", m_regs[1], 32'd5);
        // R2: same-word write not seen by neighbour
        step(word4(op(3,5,0,0,9), op(1,6,5,0,0), 0, 0), 1, 0, "R2 same word read");
        chk("R2 r6 got old r5", m_regs[6], 32'd0);
        // R5: slow add latency two, stale read in between
        step(word4(op(4,7,1,2,0), 0, 0, 0), 1, 0, "R5 slow issue");
        step(word4(op(1,8,7,0,0), 0, 0, 0), 1, 0, "R5 early read");
        chk("R5 r8 stale", m_regs[8], 32'd0);
        step(word4(op(1,9,7,0,0), 0, 0, 0), 1, 0, "R5 late read");
        chk("R5 r9 fresh", m_regs[9], 32'd12);
        // R7: stall holds pending slow result
        step(word4(op(4,10,2,2,0), 0, 0, 0), 1, 0, "R7 slow before stall");
        for (int i = 0; i < 3; i++) step(word4(op(3,11,0,0,1), 0, 0, 0), 1, 1, "R7 stalled");
        step('0, 1, 0, "R7 resume");
        chk("R7 r10 retired", m_regs[10], 32'd14);
        // R6: several jumps, lowest slot wins, other ops complete
        step(word4(op(3,12,0,0,3), op(5,0,0,0,12'h040), op(3,13,0,0,4), op(5,0,0,0,12'h080)), 1, 0, "R6 multi jump");
        chk("R6 pc target", {20'd0, m_pc}, 32'h40);
        step('0, 0, 0, "R6 bubble hold");
        // R9: r0 writes ignored, no conflict
        step(word4(op(3,0,0,0,5), op(3,0,0,0,6), op(3,16,0,0,2), 0), 1, 0, "R9 zero reg");
        chk("R9 flag clear", {31'd0, m_conf}, 32'd0);
        // R8: fast-fast collision, higher slot wins
        step(word4(op(3,11,0,0,1), 0, op(3,11,0,0,2), 0), 1, 0, "R8 fast clash");
        chk("R8 r11 slot2", m_regs[11], 32'd2);
        // R8: delayed slot3 vs fast slot1 same cycle
        step(word4(0, 0, 0, op(4,14,1,1,0)), 1, 0, "R8 slow issue");
        step(word4(0, op(3,14,0,0,1), 0, 0), 1, 0, "R8 slow vs fast");
        chk("R8 r14 delayed slot3", m_regs[14], 32'd10);

        // random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [127:0] w;
            logic v, st;
            for (int s = 0; s < 4; s++) begin
                int o;
                o = $urandom % 8;
                w[32*s +: 32] = op(o, $urandom % 32, $urandom % 16, $urandom % 16, $urandom % 8192);
            end
            v  = ($urandom % 10) != 0;
            st = ($urandom % 7) == 0;
            step(w, v, st, "R2 R5 R6 R7 R8 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule